// File: doc/BRIEF.md
# Thermocouple Converter Polling Controller

This block keeps a serial thermocouple-to-digital converter busy without any help from software. After reset it waits through a long hold-off so the converter can power up and finish its first conversion. It then reads one 32-bit result frame per conversion period over a read-only, mode-0 SPI link. Each completed frame is split into a signed thermocouple temperature, a signed cold-junction temperature and a set of fault flags, which stay on parallel output registers until the next frame completes.

Timing is fixed at build time. `CLK_MHZ` gives the system clock rate. `SCLK_HALF` is the number of system cycles in each SCLK phase, and its default is the smallest value that keeps SCLK at or below 5 MHz. `STARTUP_CYC` and `PERIOD_CYC` default to 300 ms and 100 ms at that clock, and can be overridden with short cycle counts. Reset is active low. It takes effect at once and is released through a two-stage synchronizer.

Top module: `thermo_poll_ctrl`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sclk` is 0 and all three data outputs are zero. This takes effect asynchronously, with no clock edge needed.
- R2: After `rst_n` rises, the first falling edge of `spi_cs_n` comes no earlier than `STARTUP_CYC` and no later than `STARTUP_CYC`+5 clock cycles later.
- R3: Once polling runs, consecutive falling edges of `spi_cs_n` are exactly `PERIOD_CYC` clock cycles apart.
- R4: The link is mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. Each frame has exactly 32 SCLK rising edges. `spi_miso` is sampled on each rising edge, most significant frame bit first.
- R5: Every SCLK high phase and every low phase within a frame lasts `SCLK_HALF` cycles. The default `SCLK_HALF` = ceil(`CLK_MHZ`/10), which keeps SCLK at or below 5 MHz.
- R6: `tc_temp` equals frame bits 31:18. It is a 14-bit two's complement value at 0.25 °C per LSB.
- R7: `cj_temp` equals frame bits 15:4. It is a 12-bit two's complement value at 0.0625 °C per LSB.
- R8: `fault_flags` is {frame bit 16 (any fault), bit 2 (short to VCC), bit 1 (short to GND), bit 0 (open circuit)}, with the any-fault flag in `fault_flags[3]`.
- R9: Frame bits 17 and 3 have no effect on any output.
- R10: The data outputs change only while `spi_cs_n` is high. They show a new frame within 3 cycles of `spi_cs_n` rising and hold it until the next frame completes.
- R11: A reset that arrives in the middle of a frame aborts it. After release, the controller repeats the hold-off and then delivers correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | output | 1 | Serial clock to the converter, idle low |
| spi_cs_n | output | 1 | Converter select, active low |
| spi_miso | input | 1 | Serial data from the converter |
| tc_temp | output | 14 | Thermocouple temperature, two's complement |
| cj_temp | output | 12 | Cold-junction temperature, two's complement |
| fault_flags | output | 4 | {any fault, short to VCC, short to GND, open circuit} |

## Verification
The assertions check the link's timing on every cycle:
- SCLK stays idle low outside a frame.
- Every SCLK phase lasts at least `SCLK_HALF` cycles.
- Each frame has 32 rising edges.
- Frames start exactly one period apart.
- The outputs stay still while the converter is selected.

Only the bench's scenarios can show the rest: the field mapping of real frames, reserved bits being ignored, the asynchronous clear and the start-up hold-off. These scenarios use a behavioural converter that serves directed and random frames, including a reset in the middle of a frame.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  localparam int FRAME_BITS = 32;
  localparam int TC_W       = 14;
  localparam int CJ_W       = 12;
  localparam int FLT_W      = 4;

  // Field positions decoded from the converter frame
  localparam int TC_LSB   = 18;
  localparam int CJ_LSB   = 4;
  localparam int FLT_ANY  = 16;
  localparam int FLT_SCV  = 2;
  localparam int FLT_SCG  = 1;
  localparam int FLT_OPEN = 0;
  localparam int RSVD_HI  = 17;
  localparam int RSVD_LO  = 3;

  typedef enum logic [1:0] {
    SEQ_HOLDOFF = 2'd0,
    SEQ_LAUNCH  = 2'd1,
    SEQ_WAIT    = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic any;
    logic short_vcc;
    logic short_gnd;
    logic open_tc;
  } fault_t;

  function automatic fault_t get_faults(input logic [FRAME_BITS-1:0] f);
    fault_t r;
    r.any       = f[FLT_ANY];
    r.short_vcc = f[FLT_SCV];
    r.short_gnd = f[FLT_SCG];
    r.open_tc   = f[FLT_OPEN];
    return r;
  endfunction

endpackage

// File: rtl/tcp_rst_sync.sv
module tcp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tcp_seq.sv
module tcp_seq
  import tcp_pkg::*;
#(
  parameter int STARTUP_CYC = 1000,
  parameter int PERIOD_CYC  = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic launch_o
);

  localparam int MAX_CYC    = (STARTUP_CYC > PERIOD_CYC) ? STARTUP_CYC : PERIOD_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int HOLD_LAST  = STARTUP_CYC - 1;
  localparam int PAUSE_LAST = PERIOD_CYC - 2;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             state_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    state_en = 1'b0;
    launch_o = 1'b0;
    case (state_q)
      SEQ_HOLDOFF: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_W'(HOLD_LAST)) begin
          state_d  = SEQ_LAUNCH;
          state_en = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_LAUNCH: begin
        launch_o = 1'b1;
        state_d  = SEQ_WAIT;
        state_en = 1'b1;
        cnt_en   = 1'b1;
        cnt_d    = '0;
      end
      SEQ_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_W'(PAUSE_LAST)) begin
          state_d  = SEQ_LAUNCH;
          state_en = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d  = SEQ_HOLDOFF;
        state_en = 1'b1;
        cnt_en   = 1'b1;
        cnt_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOLDOFF;
      cnt_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/tcp_spi_rx.sv
module tcp_spi_rx #(
  parameter int FRAME_BITS = 32,
  parameter int SCLK_HALF  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] frame_o
);

  localparam int HW = $clog2(SCLK_HALF + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic                  busy_q, busy_d;
  logic                  sclk_q, sclk_d;
  logic                  csn_q, csn_d;
  logic                  done_q, done_d;
  logic [HW-1:0]         hcnt_q, hcnt_d;
  logic [BW-1:0]         bits_q, bits_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic                  tick;
  logic                  shift_en;

  assign tick = busy_q && (hcnt_q == HW'(SCLK_HALF - 1));

  always_comb begin
    busy_d   = busy_q;
    sclk_d   = sclk_q;
    csn_d    = csn_q;
    hcnt_d   = hcnt_q;
    bits_d   = bits_q;
    shift_d  = shift_q;
    shift_en = 1'b0;
    done_d   = 1'b0;
    if (!busy_q) begin
      if (launch_i) begin
        busy_d = 1'b1;
        csn_d  = 1'b0;
        sclk_d = 1'b0;
        hcnt_d = '0;
        bits_d = '0;
      end
    end else begin
      hcnt_d = tick ? '0 : hcnt_q + 1'b1;
      if (tick) begin
        if (sclk_q) begin
          sclk_d = 1'b0;
        end else if (bits_q != BW'(FRAME_BITS)) begin
          sclk_d   = 1'b1;
          shift_en = 1'b1;
          shift_d  = {shift_q[FRAME_BITS-2:0], miso_i};
          bits_d   = bits_q + 1'b1;
        end else begin
          busy_d = 1'b0;
          csn_d  = 1'b1;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      done_q <= 1'b0;
      hcnt_q <= '0;
      bits_q <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      done_q <= done_d;
      hcnt_q <= hcnt_d;
      bits_q <= bits_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign cs_n_o  = csn_q;
  assign done_o  = done_q;
  assign frame_o = shift_q;

endmodule

// File: rtl/tcp_unpack.sv
module tcp_unpack
  import tcp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic [TC_W-1:0]       tc_o,
  output logic [CJ_W-1:0]       cj_o,
  output logic [FLT_W-1:0]      flt_o
);

  logic [TC_W-1:0]  tc_q;
  logic [CJ_W-1:0]  cj_q;
  fault_t           flt_q;
  fault_t           flt_d;
  logic             unused_rsvd;

  assign flt_d       = get_faults(frame_i);
  assign unused_rsvd = frame_i[RSVD_HI] ^ frame_i[RSVD_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= '0;
      cj_q  <= '0;
      flt_q <= '0;
    end else if (load_i) begin
      tc_q  <= frame_i[TC_LSB +: TC_W];
      cj_q  <= frame_i[CJ_LSB +: CJ_W];
      flt_q <= flt_d;
    end
  end

  assign tc_o  = tc_q;
  assign cj_o  = cj_q;
  assign flt_o = flt_q;

endmodule

// File: rtl/thermo_poll_ctrl.sv
module thermo_poll_ctrl
  import tcp_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int SCLK_HALF   = (CLK_MHZ + 9) / 10,
  parameter int STARTUP_CYC = CLK_MHZ * 300_000,
  parameter int PERIOD_CYC  = CLK_MHZ * 100_000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            spi_sclk,
  output logic            spi_cs_n,
  input  logic            spi_miso,
  output logic [TC_W-1:0] tc_temp,
  output logic [CJ_W-1:0] cj_temp,
  output logic [FLT_W-1:0] fault_flags
);

  logic                  rst_n_int;
  logic                  launch;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame;

  tcp_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  tcp_seq #(
    .STARTUP_CYC (STARTUP_CYC),
    .PERIOD_CYC  (PERIOD_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .launch_o (launch)
  );

  tcp_spi_rx #(
    .FRAME_BITS (FRAME_BITS),
    .SCLK_HALF  (SCLK_HALF)
  ) u_spi (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .launch_i (launch),
    .miso_i   (spi_miso),
    .sclk_o   (spi_sclk),
    .cs_n_o   (spi_cs_n),
    .done_o   (frame_done),
    .frame_o  (frame)
  );

  tcp_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (frame_done),
    .frame_i (frame),
    .tc_o    (tc_temp),
    .cj_o    (cj_temp),
    .flt_o   (fault_flags)
  );

endmodule

// File: rtl/tcp_checker.sv
module tcp_checker #(
  parameter int SCLK_HALF  = 5,
  parameter int PERIOD_CYC = 400,
  parameter int FRAME_BITS = 32,
  parameter int OUT_W      = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic [OUT_W-1:0] outs
);

  localparam int HOLD_W = $clog2(SCLK_HALF + 2);
  localparam int GAP_W  = $clog2(PERIOD_CYC + 2);
  localparam int EDG_W  = $clog2(FRAME_BITS + 2);

  logic              sclk_p, cs_p, seen_fall;
  logic [HOLD_W-1:0] hold;
  logic [GAP_W-1:0]  gap;
  logic [EDG_W-1:0]  edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p    <= 1'b0;
      cs_p      <= 1'b1;
      seen_fall <= 1'b0;
      hold      <= HOLD_W'(SCLK_HALF);
      gap       <= '0;
      edges     <= '0;
    end else begin
      sclk_p <= sclk;
      cs_p   <= cs_n;
      if (sclk != sclk_p) hold <= HOLD_W'(1);
      else if (hold < HOLD_W'(SCLK_HALF)) hold <= hold + 1'b1;
      if (!cs_n && cs_p) begin
        gap       <= GAP_W'(1);
        seen_fall <= 1'b1;
        edges     <= '0;
      end else begin
        if (gap < GAP_W'(PERIOD_CYC + 1)) gap <= gap + 1'b1;
        if (sclk && !sclk_p && edges < EDG_W'(FRAME_BITS + 1)) edges <= edges + 1'b1;
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R4

  AST_SCLK_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_p) |-> (hold >= HOLD_W'(SCLK_HALF))); // R5

  AST_EDGES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_p) |-> (edges == EDG_W'(FRAME_BITS))); // R4

  AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_p && seen_fall) |-> (gap == GAP_W'(PERIOD_CYC))); // R3

  AST_OUT_HOLD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outs) |-> cs_n); // R10

endmodule

bind thermo_poll_ctrl tcp_checker #(
  .SCLK_HALF  (SCLK_HALF),
  .PERIOD_CYC (PERIOD_CYC),
  .FRAME_BITS (32),
  .OUT_W      (30)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .sclk  (spi_sclk),
  .cs_n  (spi_cs_n),
  .outs  ({tc_temp, cj_temp, fault_flags})
);

// File: tb/thermo_poll_ctrl_tb_top.sv
module thermo_poll_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 3;
  localparam int STARTUP    = 500;
  localparam int PERIOD     = 300;
  localparam int FRAMES     = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_miso;
  logic        spi_sclk, spi_cs_n;
  logic [13:0] tc_temp;
  logic [11:0] cj_temp;
  logic [3:0]  fault_flags;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] cur_frame;
  int          bit_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_poll_ctrl #(
    .CLK_MHZ     (25),
    .SCLK_HALF   (SCLK_HALF),
    .STARTUP_CYC (STARTUP),
    .PERIOD_CYC  (PERIOD)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .tc_temp     (tc_temp),
    .cj_temp     (cj_temp),
    .fault_flags (fault_flags)
  );

  // Behavioural converter: MSB out on select, next bit after each SCLK fall
  always @(negedge spi_cs_n) bit_idx = 0;
  always @(negedge spi_sclk) if (!spi_cs_n) bit_idx = bit_idx + 1;
  assign spi_miso = (!spi_cs_n && bit_idx < 32) ? cur_frame[31 - bit_idx] : 1'b0;

  function automatic logic [13:0] exp_tc(input logic [31:0] f);
    return f[31:18];
  endfunction
  function automatic logic [11:0] exp_cj(input logic [31:0] f);
    return f[15:4];
  endfunction
  function automatic logic [3:0] exp_flt(input logic [31:0] f);
    return {f[16], f[2], f[1], f[0]};
  endfunction

  function automatic logic [31:0] pick_frame(input int k);
    case (k)
      0: return 32'hFFFF_FFFF;
      1: return 32'h0002_0008;
      2: return 32'h8000_0000;
      3: return 32'h7FFC_7FF0;
      4: return 32'h0001_0005;
      5: return 32'h0000_0000;
      6: return 32'h0001_0002;
      default: return $urandom();
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Link timing monitor, sampled on the falling clock edge
  logic cs_prev = 1'b1, sclk_prev = 1'b0, have_fall = 1'b0;
  int   cyc = 0, last_fall = 0, hi_run = 0, rises = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      have_fall = 1'b0;
      rises     = 0;
      hi_run    = 0;
    end else begin
      if (!spi_cs_n && cs_prev) begin
        if (have_fall)
          check(cyc - last_fall == PERIOD, "R3", "frame spacing", cyc - last_fall, PERIOD);
        have_fall = 1'b1;
        last_fall = cyc;
        rises     = 0;
      end
      if (spi_sclk && !sclk_prev) rises++;
      if (spi_sclk) hi_run++;
      if (!spi_sclk && sclk_prev) begin
        check(hi_run == SCLK_HALF, "R5", "sclk high width", hi_run, SCLK_HALF);
        hi_run = 0;
      end
      if (spi_cs_n && !cs_prev)
        check(rises == 32, "R4", "rising edges per frame", rises, 32);
      if (spi_cs_n && spi_sclk)
        check(1'b0, "R4", "sclk high while deselected", 1, 0);
    end
    cs_prev   = spi_cs_n;
    sclk_prev = spi_sclk;
  end

  task automatic check_frame(input logic [31:0] f, input string req);
    check(tc_temp == exp_tc(f), req, "tc_temp", 32'(tc_temp), 32'(exp_tc(f)));
    check(cj_temp == exp_cj(f), req, "cj_temp", 32'(cj_temp), 32'(exp_cj(f)));
    check(fault_flags == exp_flt(f), req, "fault_flags", 32'(fault_flags), 32'(exp_flt(f)));
  endtask

  task automatic measure_holdoff(input string req);
    int w = 0;
    while (spi_cs_n) begin
      @(negedge clk);
      w++;
    end
    check(w >= STARTUP && w <= STARTUP + 5, req, "hold-off cycles", w, STARTUP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", 200000);
    finish_run();
  end

  initial begin
    logic [31:0] done_frame;
    void'($urandom(32'h5EED_0042));
    rst_n     = 1'b0;
    cur_frame = pick_frame(0);
    repeat (5) @(negedge clk);
    // R1: reset state
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "pins in reset", {spi_cs_n, spi_sclk}, 2'b10);
    check({tc_temp, cj_temp, fault_flags} === '0, "R1", "outputs in reset",
          32'({tc_temp, cj_temp, fault_flags}), 0);
    rst_n = 1'b1;
    measure_holdoff("R2");

    for (int k = 0; k < FRAMES; k++) begin
      done_frame = cur_frame;
      @(posedge spi_cs_n);
      repeat (3) @(negedge clk);
      check_frame(done_frame, "R6 R7 R8");
      if (done_frame == 32'h0002_0008)
        check({tc_temp, cj_temp, fault_flags} == '0, "R9", "reserved bits ignored",
              32'({tc_temp, cj_temp, fault_flags}), 0);
      cur_frame = pick_frame(k + 1);
      @(negedge spi_cs_n);
      repeat (40) @(negedge clk);
      check_frame(done_frame, "R10");
    end

    // R11: reset in the middle of a frame
    repeat (30) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 R11", "pins after async reset",
          {spi_cs_n, spi_sclk}, 2'b10);
    check({tc_temp, cj_temp, fault_flags} === '0, "R1 R11", "outputs after async reset",
          32'({tc_temp, cj_temp, fault_flags}), 0);
    repeat (4) @(negedge clk);
    cur_frame = 32'hA5A5_5A5A;
    rst_n = 1'b1;
    measure_holdoff("R11");
    done_frame = cur_frame;
    @(posedge spi_cs_n);
    repeat (3) @(negedge clk);
    check_frame(done_frame, "R11");
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule